// File: doc/BRIEF.md
# Multicore Inter-Processor Interrupt Hub

This block is a shared unit through which any of up to eight cores can interrupt any other core. Every core has one interrupt output line. A core issues a command on a shared command port. Each command carries the issuing core's id and one operand naming another core. The hub keeps one pending bit for every ordered (sender, target) pair of cores. It drives each target's line high while any sender's bit toward that target is set.

Four commands exist. A status query lets a sender check whether its last interrupt toward a target is still unacknowledged. A raise command sets the sender-to-target bit. A source query returns, as a mask, every core with an interrupt outstanding toward the caller. When several cores interrupt the same target at once, that target sees only one asserted line and gets a mask with several bits set. An acknowledge command clears exactly one sender's bit toward the caller, so the caller handles a multi-bit mask one bit at a time.

Answers appear in a readback register on the cycle after the query. Commands are taken one per cycle. Bus fabric, the core-side interrupt controller and software locking sit outside this block.

Top module: `ipi_hub`

## Requirements
- R1: After reset every interrupt line is low and the readback register is zero.
- R2: A raise command (cmdOp = 1) from caller c with operand t sets the pending bit c-to-t, so that ipiLine[t] is high from the cycle after the command.
- R3: A status query (cmdOp = 0) from caller c with operand t loads the readback register, on the cycle after the command, with bit 0 equal to 1 if the c-to-t bit is still set and 0 otherwise; all higher bits are zero.
- R4: A source query (cmdOp = 2) from caller c loads the readback register, on the cycle after the command, with a mask whose bit k is 1 exactly when the k-to-c bit is set.
- R5: When several senders have bits set toward the same target, only that target's single line is high, and its source query returns a mask with one bit per sender.
- R6: An acknowledge command (cmdOp = 3) from caller c with operand s clears only the s-to-c bit. ipiLine[c] falls only when no sender bit toward c remains set.
- R7: A raise toward a pair whose bit is already set leaves the bit set and changes nothing else. A single acknowledge then clears it.
- R8: A command is ignored, with no change to any pending bit or to the readback register, if its caller id is at or above NUM_CORES, or if it is a status, raise or acknowledge command whose operand is at or above NUM_CORES.
- R9: The readback register keeps its value on idle cycles and on raise and acknowledge commands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | A command is presented this cycle |
| cmdOp | input | 2 | Command code: 0 status query, 1 raise, 2 source query, 3 acknowledge |
| cmdCore | input | 3 | Id of the issuing core |
| cmdArg | input | 3 | Target core (status, raise) or sender core (acknowledge) |
| rdData | output | NUM_CORES | Readback register |
| ipiLine | output | NUM_CORES | One interrupt line per core |

## Verification
The pending-bit update caused by one command and the readback capture of the next command fall on adjacent clock edges. A query issued in the cycle right after a raise or acknowledge must therefore already see the new matrix. The bench provokes this by issuing commands back to back with no idle cycles between them. It does this in directed sequences (several raises toward one core, then acknowledges each followed immediately by a source query) and in a long random stream. After every command it compares the readback register and all lines against a pending matrix kept in the bench. A second overlap is a raise landing on a target whose line is already high from another sender. That case is judged by the line staying high and by the source mask gaining exactly one bit.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  // Core ids travel in a fixed 3-bit field; up to eight cores are addressable.
  localparam int IdxW = 3;

  typedef enum logic [1:0] {
    OP_STATUS = 2'd0,
    OP_RAISE  = 2'd1,
    OP_SOURCE = 2'd2,
    OP_ACK    = 2'd3
  } ipi_op_e;

  // Strobes from the decoder into the pending matrix and readback register.
  typedef struct packed {
    logic            stsEn;  // status query, operand = target
    logic            setEn;  // raise, operand = target
    logic            srcEn;  // source query, no operand
    logic            clrEn;  // acknowledge, operand = sender
    logic [IdxW-1:0] self;   // issuing core
    logic [IdxW-1:0] peer;   // operand core
  } ipi_strobe_t;

endpackage

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  input  logic [1:0]      cmdOp,
  input  logic [IdxW-1:0] cmdCore,
  input  logic [IdxW-1:0] cmdArg,
  output ipi_strobe_t     strb
);

  logic    selfOk;
  logic    peerOk;
  ipi_op_e opCode;

  assign opCode = ipi_op_e'(cmdOp);
  assign selfOk = int'(cmdCore) < NUM_CORES;
  assign peerOk = int'(cmdArg) < NUM_CORES;

  always_comb begin
    strb       = '0;
    strb.self  = cmdCore;
    strb.peer  = cmdArg;
    if (cmdValid && selfOk) begin
      unique case (opCode)
        OP_STATUS: strb.stsEn = peerOk;
        OP_RAISE:  strb.setEn = peerOk;
        OP_SOURCE: strb.srcEn = 1'b1;
        OP_ACK:    strb.clrEn = peerOk;
        default:   ;
      endcase
    end
  end

  // R8: at most one action per cycle
  p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.stsEn, strb.setEn, strb.srcEn, strb.clrEn}));

  // R8: an out-of-range caller produces no action
  p_bad_caller_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && int'(cmdCore) >= NUM_CORES) |->
      !(strb.stsEn || strb.setEn || strb.srcEn || strb.clrEn));

  // R8: an out-of-range operand blocks every operand-carrying command
  p_bad_operand_r8: assert property (@(posedge clk) disable iff (!rstN)
    (int'(cmdArg) >= NUM_CORES) |-> !(strb.stsEn || strb.setEn || strb.clrEn));

endmodule

// File: rtl/ipi_datapath.sv
module ipi_datapath
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ipi_strobe_t          strb,
  output logic [NUM_CORES-1:0] rdData,
  output logic [NUM_CORES-1:0] ipiLine
);

  localparam int SelW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  // pendRow[s][t]: sender s has an unacknowledged interrupt toward target t
  logic [NUM_CORES-1:0] pendRow [NUM_CORES];
  // colBits[t][s]: the same matrix seen per target
  logic [NUM_CORES-1:0] colBits [NUM_CORES];

  logic [SelW-1:0] selfIdx;
  logic [SelW-1:0] peerIdx;

  assign selfIdx = strb.self[SelW-1:0];
  assign peerIdx = strb.peer[SelW-1:0];

  for (genvar s = 0; s < NUM_CORES; s++) begin : g_sender
    localparam logic [IdxW-1:0] SId = IdxW'(s);
    for (genvar t = 0; t < NUM_CORES; t++) begin : g_target
      localparam logic [IdxW-1:0] TId = IdxW'(t);
      logic hitSet;
      logic hitClr;
      assign hitSet = strb.setEn && (strb.self == SId) && (strb.peer == TId);
      assign hitClr = strb.clrEn && (strb.peer == SId) && (strb.self == TId);

      always_ff @(posedge clk) begin
        if (!rstN)       pendRow[s][t] <= 1'b0;
        else if (hitSet) pendRow[s][t] <= 1'b1;
        else if (hitClr) pendRow[s][t] <= 1'b0;
      end

      assign colBits[t][s] = pendRow[s][t];
    end
  end

  for (genvar t = 0; t < NUM_CORES; t++) begin : g_line
    assign ipiLine[t] = |colBits[t];

    // R6: a line can only fall in the cycle after its owner acknowledges
    p_line_drop_only_on_ack_r6: assert property (@(posedge clk) disable iff (!rstN)
      (ipiLine[t] && !(strb.clrEn && int'(strb.self) == t)) |=> ipiLine[t]);
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      rdData <= '0;
    else if (strb.stsEn)
      rdData <= {{(NUM_CORES-1){1'b0}}, pendRow[selfIdx][peerIdx]};
    else if (strb.srcEn)
      rdData <= colBits[selfIdx];
  end

  // R2: a raise makes the target line high on the next cycle
  p_raise_sets_line_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.setEn |=> ipiLine[$past(peerIdx)]);

  // R6: an acknowledge removes the addressed sender bit
  p_ack_clears_pair_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrEn |=> !pendRow[$past(peerIdx)][$past(selfIdx)]);

  // R3: a status answer never uses bits above bit 0
  p_status_narrow_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.stsEn |=> (rdData[NUM_CORES-1:1] == '0));

  // R9: the readback register only moves on queries
  p_readback_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.stsEn || strb.srcEn) |=> $stable(rdData));

endmodule

// File: rtl/ipi_hub.sv
module ipi_hub
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [1:0]           cmdOp,
  input  logic [2:0]           cmdCore,
  input  logic [2:0]           cmdArg,
  output logic [NUM_CORES-1:0] rdData,
  output logic [NUM_CORES-1:0] ipiLine
);

  ipi_strobe_t strb;

  ipi_ctrl #(.NUM_CORES(NUM_CORES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .cmdCore  (cmdCore),
    .cmdArg   (cmdArg),
    .strb     (strb)
  );

  ipi_datapath #(.NUM_CORES(NUM_CORES)) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .rdData  (rdData),
    .ipiLine (ipiLine)
  );

  // R1: lines and readback come out of reset cleared
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(!rstN) |-> (ipiLine == '0 && rdData == '0));

endmodule

// File: tb/test_ipi_hub.sv
`timescale 1ns/1ps
module test_ipi_hub;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cmdValid = 1'b0;
  logic [1:0]   cmdOp = 2'd0;
  logic [2:0]   cmdCore = 3'd0;
  logic [2:0]   cmdArg = 3'd0;
  logic [N-1:0] rdData;
  logic [N-1:0] ipiLine;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  bit [7:0]     mdl [8];   // mdl[s][t]: sender s pending toward target t
  logic [N-1:0] expRd;

  ipi_hub #(.NUM_CORES(N)) i_ipi_hub (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdCore(cmdCore), .cmdArg(cmdArg), .rdData(rdData), .ipiLine(ipiLine)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      bad = bad + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
      $display("  test done: total=%0d bad=%0d", total + 1, bad);
      $finish;
    end
  end

  function automatic logic [N-1:0] lineVec();
    logic [N-1:0] v = '0;
    for (int t = 0; t < N; t++)
      for (int s = 0; s < N; s++)
        if (mdl[s][t]) v[t] = 1'b1;
    return v;
  endfunction

  function automatic logic [N-1:0] srcMask(int c);
    logic [N-1:0] v = '0;
    for (int s = 0; s < N; s++) v[s] = mdl[s][c];
    return v;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one command at a negedge, update the model at the edge, check at the next negedge.
  task automatic doCmd(int op, int caller, int arg);
    string tagRd;
    string tagLn;
    bit    valid;
    cmdValid = 1'b1;
    cmdOp    = 2'(op);
    cmdCore  = 3'(caller);
    cmdArg   = 3'(arg);
    valid = (caller < N) && (op == 2 || arg < N);
    @(posedge clk);
    tagRd = "R9";
    tagLn = "R2";
    if (!valid) begin
      tagRd = "R8"; tagLn = "R8";
    end else begin
      case (op)
        0: begin expRd = {{(N-1){1'b0}}, mdl[caller][arg]}; tagRd = "R3"; tagLn = "R3"; end
        1: begin mdl[caller][arg] = 1'b1; tagLn = "R2"; end
        2: begin expRd = srcMask(caller); tagRd = "R4"; tagLn = "R5"; end
        default: begin mdl[arg][caller] = 1'b0; tagLn = "R6"; end
      endcase
    end
    @(negedge clk);
    check(rdData === expRd, tagRd, 32'(rdData), 32'(expRd));
    check(ipiLine === lineVec(), tagLn, 32'(ipiLine), 32'(lineVec()));
  endtask

  task automatic idle();
    cmdValid = 1'b0;
    @(negedge clk);
    check(rdData === expRd, "R9", 32'(rdData), 32'(expRd));
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    expRd = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(ipiLine === '0, "R1", 32'(ipiLine), 32'h0);
    check(rdData === '0, "R1", 32'(rdData), 32'h0);

    // R5: three senders toward core 0, single line, multi-bit mask
    doCmd(1, 1, 0);
    doCmd(1, 2, 0);
    doCmd(1, 3, 0);
    check(ipiLine === N'(1), "R5", 32'(ipiLine), 32'h1);
    doCmd(2, 0, 0);
    check(rdData === N'(4'b1110), "R5", 32'(rdData), 32'he);
    // R6: ack bit by bit, query back to back
    doCmd(3, 0, 2);
    doCmd(2, 0, 0);
    check(rdData === N'(4'b1010), "R6", 32'(rdData), 32'ha);
    check(ipiLine[0] === 1'b1, "R6", 32'(ipiLine), 32'h1);
    doCmd(3, 0, 1);
    doCmd(3, 0, 3);
    check(ipiLine === '0, "R6", 32'(ipiLine), 32'h0);

    // R7: double raise, single ack clears
    doCmd(1, 0, 1);
    doCmd(1, 0, 1);
    doCmd(0, 0, 1);
    check(rdData === N'(1), "R7", 32'(rdData), 32'h1);
    doCmd(3, 1, 0);
    doCmd(0, 0, 1);
    check(rdData === '0 && ipiLine === '0, "R7", 32'(ipiLine), 32'h0);

    // R8: bad caller and bad operand have no effect
    doCmd(1, 2, 3);
    doCmd(2, 3, 0);
    doCmd(1, 5, 3);
    doCmd(1, 2, 6);
    doCmd(0, 2, 7);
    check(rdData === N'(4'b0100), "R8", 32'(rdData), 32'h4);
    doCmd(3, 3, 2);
    idle();

    // Random back-to-back stream
    void'($urandom(32'd20240611));
    for (int k = 0; k < 600; k++) begin
      int op;
      int c;
      int a;
      op = int'($urandom_range(0, 3));
      c  = ($urandom_range(0, 9) == 0) ? int'($urandom_range(4, 7)) : int'($urandom_range(0, N - 1));
      a  = ($urandom_range(0, 9) == 0) ? int'($urandom_range(4, 7)) : int'($urandom_range(0, N - 1));
      doCmd(op, c, a);
      if ($urandom_range(0, 7) == 0) idle();
    end
    idle();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule